// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block models a byte-addressed serial EEPROM that sits behind a two-wire serial bus. It takes the bus clock line and the incoming data line as levels that are already sampled into the system clock domain. It returns the data bit the memory would pull onto the bus. Start and stop conditions frame a transaction. A single bit-cycle counter moves forward on each rising bus clock edge and jumps back at points that depend on the mode. Command, address and write-data bits are taken on the falling bus clock edge. Read data leaves the block most significant bit first.

A two-bit mode input picks the addressing scheme. The compact scheme packs a 7-bit word address and the direction bit into one command byte. The other two schemes send a device byte followed by one or two word-address bytes. The mode is held for the whole of a transaction. The storage array has `MEM_AW` address bits, and a logical address wider than the array aliases onto its low bits.

There is no stream traffic at the edge of the block. All pins are plain levels, with no valid/ready pairing and no back-pressure.

Top module: `two_wire_eeprom`

## Requirements
- R1: After reset every memory byte, the address register and the bit-cycle counter are zero, no transaction is open, and `sda_out` follows `sda_in` with one clock of delay.
- R2: A start condition is `sda_in` falling while `scl_in` stays high. It opens a transaction and clears the bit-cycle counter but keeps the address register, so a repeated start followed by a read command reads from the current address.
- R3: A stop condition is `sda_in` rising while `scl_in` stays high. It closes the transaction, and afterwards `sda_out` follows `sda_in` again.
- R4: The mode encoding is 0 for the compact scheme, 1 for the 8-bit word address and 2 or 3 for the 16-bit word address. The mode input is taken only while no transaction is open.
- R5: In the compact scheme, bits 1 to 8 carry the word address MSB first and then the direction bit (1 = read). Bit 9 is an acknowledge and bits 10 to 17 carry one data byte. The 18th rising edge takes the counter back to 9.
- R6: In the compact scheme, each written byte advances only word-address bits 1:0, which gives a 4-byte page.
- R7: In the compact scheme, each byte read advances the 7-bit word address by one, wrapping from 127 to 0.
- R8: In the 8-bit scheme the device byte is `1010 a10 a9 a8 rw`. Its bits 3:1 become address bits 10:8, the next byte gives bits 7:0, and write data follows in bits 19 to 26 with the counter going from 27 back to 18.
- R9: In the 16-bit scheme the device byte is followed by a high and a low address byte that form a 13-bit address. Data occupies bits 28 to 35, and the counter goes from 36 back to 27.
- R10: In both the 8-bit and 16-bit schemes, each written byte advances only address bits 3:0, which gives a 16-byte page.
- R11: In a read, the data bit of index (17 − counter) comes out while the counter is 10 to 17. The next rising edge takes the counter back to 9 and adds one to the address (13-bit wrap in the wider schemes).
- R12: While a transaction is open and the counter is 9, 18 or 27, `sda_out` is 0.
- R13: The counter moves and memory is written only inside an open transaction. Clock pulses outside one leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Sampled bus clock level |
| sda_in | input | 1 | Sampled bus data level driven by the host |
| mode | input | 2 | Addressing scheme: 0 compact, 1 8-bit, 2/3 16-bit |
| sda_out | output | 1 | Data level returned by the memory |

## Verification
The assertions assume both bus lines are already in the system clock domain and never change in the same clock. Each level is also assumed to be held for at least one clock, so every edge and every start or stop is seen exactly once. The stimulus moves one line at a time and keeps each phase for several clocks. It changes data only while the bus clock is low, except where it means to form a start or a stop. Randomised transactions keep their addresses inside the span the chosen mode can reach.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int LA_W  = 13;  // widest logical byte address
  localparam int CYC_W = 6;   // bit-cycle counter, largest value 35

  typedef enum logic [1:0] {
    EM_TINY = 2'd0,
    EM_A8   = 2'd1,
    EM_A16  = 2'd2,
    EM_A16B = 2'd3
  } eep_mode_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
    logic sda;
  } eep_evt_t;

  function automatic logic is_ack_cyc(input logic [CYC_W-1:0] c);
    return (c == CYC_W'(9)) || (c == CYC_W'(18)) || (c == CYC_W'(27));
  endfunction
endpackage

// File: rtl/eep_edge.sv
module eep_edge
  import eep_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl,
  input  logic     sda,
  output eep_evt_t evt,
  output logic     sda_last
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  always_comb begin
    evt.start = scl_q & scl & sda_q & ~sda;
    evt.stop  = scl_q & scl & ~sda_q & sda;
    evt.rise  = ~scl_q & scl;
    evt.fall  = scl_q & ~scl;
    evt.sda   = sda;
  end

  assign sda_last = sda_q;

  // R2/R3: a start and a stop can never fire together
  a_r2_start_stop_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt.start && evt.stop));
endmodule

// File: rtl/eep_seq.sv
module eep_seq
  import eep_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  eep_evt_t          evt,
  input  logic [1:0]        mode_in,
  output logic              started,
  output logic [CYC_W-1:0]  cyc,
  output logic              rd_flag,
  output logic [MEM_AW-1:0] mem_idx,
  output logic              wr_en,
  output logic              wr_bit
);
  eep_mode_e        mode_q;
  logic [LA_W-1:0]  addr, addr_n;
  logic [7:0]       dev, dev_n;
  logic [CYC_W-1:0] cyc_n, nx;
  logic             tiny, wide16, data_zone;

  assign tiny   = (mode_q == EM_TINY);
  assign wide16 = mode_q[1];
  assign nx     = cyc + CYC_W'(1);

  always_comb begin
    rd_flag = tiny ? addr[0] : dev[0];
    if (tiny) mem_idx = MEM_AW'(addr[7:1]);
    else      mem_idx = addr[MEM_AW-1:0];
    data_zone = wide16 ? (cyc > CYC_W'(27)) : (cyc > CYC_W'(18));
  end

  // next-state of counter, address and device byte
  always_comb begin
    cyc_n  = cyc;
    addr_n = addr;
    dev_n  = dev;
    wr_en  = 1'b0;
    wr_bit = evt.sda;
    if (started && evt.rise) begin
      if (tiny) begin
        if (nx == CYC_W'(18)) begin
          cyc_n = CYC_W'(9);
          if (addr[0]) addr_n = {5'b0, addr[7:1] + 7'd1, 1'b1};
        end else begin
          cyc_n = nx;
        end
      end else if (dev[0] && nx == CYC_W'(18)) begin
        cyc_n  = CYC_W'(9);
        addr_n = addr + LA_W'(1);
      end else if (!wide16 && nx == CYC_W'(27)) begin
        cyc_n = CYC_W'(18);
      end else if (nx == CYC_W'(36)) begin
        cyc_n = CYC_W'(27);
      end else begin
        cyc_n = nx;
      end
    end else if (started && evt.fall) begin
      if (tiny) begin
        if (cyc == CYC_W'(9)) begin
          cyc_n = cyc;
        end else if (cyc > CYC_W'(9)) begin
          if (!addr[0]) begin
            wr_en = 1'b1;
            if (cyc == CYC_W'(17)) addr_n[2:1] = addr[2:1] + 2'd1;
          end
        end else begin
          addr_n = {5'b0, addr[6:0], evt.sda};
        end
      end else if (is_ack_cyc(cyc)) begin
        cyc_n = cyc;
      end else if (data_zone) begin
        if (!dev[0]) begin
          wr_en = 1'b1;
          if (cyc == CYC_W'(26) || cyc == CYC_W'(35))
            addr_n[3:0] = addr[3:0] + 4'd1;
        end
      end else if (cyc > CYC_W'(9)) begin
        if (!dev[0]) begin
          if (wide16)
            addr_n = {addr[11:0], evt.sda};
          else if (cyc == CYC_W'(17))
            addr_n = {2'b0, dev[3:1], addr[6:0], evt.sda};
          else
            addr_n = {5'b0, addr[6:0], evt.sda};
        end
      end else begin
        dev_n = {dev[6:0], evt.sda};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      cyc     <= '0;
      addr    <= '0;
      dev     <= '0;
      mode_q  <= EM_TINY;
    end else begin
      if (!started) mode_q <= eep_mode_e'(mode_in);
      addr <= addr_n;
      dev  <= dev_n;
      if (evt.start) begin
        started <= 1'b1;
        cyc     <= '0;
      end else if (evt.stop) begin
        started <= 1'b0;
      end else begin
        cyc <= cyc_n;
      end
    end
  end

  a_r13_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !wr_en);
  a_r5_tiny_cyc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (started && tiny) |-> (cyc <= CYC_W'(17)));
  a_r9_cyc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cyc <= CYC_W'(35));
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt.start |=> (started && cyc == '0));
  a_r3_stop_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.stop && !evt.start) |=> !started);
  a_r4_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    (started && $past(started)) |-> $stable(mode_q));
  a_r11_read_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (started && !tiny && dev[0]) |-> (cyc <= CYC_W'(17)));
endmodule

// File: rtl/eep_mem.sv
module eep_mem #(
  parameter int MEM_AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic [MEM_AW-1:0] idx,
  output logic [7:0]        rd_byte
);
  localparam int DEPTH = 1 << MEM_AW;

  logic [7:0] mem [DEPTH];

  // bits shift in LSB-side, so eight falling edges leave the whole byte in place
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else if (wr_en) begin
      mem[idx] <= {mem[idx][6:0], wr_bit};
    end
  end

  assign rd_byte = mem[idx];

  // R13: the shifted byte keeps its older bits
  a_r13_shift_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) && $stable(idx) |-> (mem[idx][7:1] == $past(mem[idx][6:0])));
endmodule

// File: rtl/two_wire_eeprom.sv
module two_wire_eeprom
  import eep_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] mode,
  output logic       sda_out
);
  eep_evt_t          evt;
  logic              sda_last, started, rd_flag, wr_en, wr_bit;
  logic [CYC_W-1:0]  cyc;
  logic [MEM_AW-1:0] mem_idx;
  logic [7:0]        rd_byte;
  logic [CYC_W-1:0]  bit_pos;
  logic              in_data;

  eep_edge u_edge (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
    .evt(evt), .sda_last(sda_last)
  );

  eep_seq #(.MEM_AW(MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .evt(evt), .mode_in(mode),
    .started(started), .cyc(cyc), .rd_flag(rd_flag),
    .mem_idx(mem_idx), .wr_en(wr_en), .wr_bit(wr_bit)
  );

  eep_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .idx(mem_idx), .rd_byte(rd_byte)
  );

  assign bit_pos = CYC_W'(17) - cyc;
  assign in_data = started && rd_flag && (cyc >= CYC_W'(10)) && (cyc <= CYC_W'(17));

  always_comb begin
    if (started && is_ack_cyc(cyc)) sda_out = 1'b0;
    else if (in_data)               sda_out = rd_byte[bit_pos[2:0]];
    else                            sda_out = sda_last;
  end

  // R1/R3: with no transaction open the output repeats the last sampled level
  a_r3_idle_echo: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> (sda_out == $past(sda_in)));
endmodule

// File: tb/sim_two_wire_eeprom.sv
`timescale 1ns/1ps
module sim_two_wire_eeprom;
  localparam int AW = 11;
  localparam int DEPTH = 1 << AW;
  localparam int PH = 3;

  logic clk = 0, rst_n = 0, scl = 1, sda = 1, sda_out;
  logic [1:0] mode = 0;
  int errors = 0, checks = 0;
  bit done = 0;
  logic [7:0] ref_mem [DEPTH];
  logic [7:0] wbuf [8];

  always #2.5 clk = ~clk;

  two_wire_eeprom #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .mode(mode), .sda_out(sda_out)
  );

  task automatic wt(input int n); repeat (n) @(negedge clk); endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic int page_idx(input int m, input int a, input int k);
    if (m == 0) return (a & 7'h7C) | ((a + k) & 3);
    return (a & 11'h7F0) | ((a + k) & 15);
  endfunction

  function automatic int read_idx(input int m, input int a, input int k);
    if (m == 0) return (a + k) & 127;
    return (a + k) & (DEPTH - 1);
  endfunction

  task automatic bus_start();
    sda = 1; wt(PH); scl = 1; wt(PH); sda = 0; wt(PH); scl = 0; wt(PH);
  endtask
  task automatic bus_stop();
    sda = 0; wt(PH); scl = 1; wt(PH); sda = 1; wt(PH);
  endtask
  task automatic send_bit(input logic b);
    sda = b; wt(PH); scl = 1; wt(PH); scl = 0; wt(PH);
  endtask
  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask
  task automatic ack_chk(input string req);
    sda = 1; wt(PH); scl = 1; wt(PH);
    chk({7'b0, sda_out}, 8'h00, req);
    scl = 0; wt(PH);
  endtask
  task automatic recv_byte(output logic [7:0] b);
    sda = 1;
    for (int i = 7; i >= 0; i--) begin
      wt(PH); scl = 1; wt(PH); b[i] = sda_out; scl = 0;
    end
    wt(PH);
  endtask

  task automatic send_addr(input int m, input int a, input string req);
    if (m == 0) begin
      send_byte({a[6:0], 1'b0});
    end else if (m == 1) begin
      send_byte({4'hA, a[10:8], 1'b0}); ack_chk(req);
      send_byte(a[7:0]);
    end else begin
      send_byte({4'hA, 3'b0, 1'b0}); ack_chk(req);
      send_byte({3'b0, a[12:8]}); ack_chk(req);
      send_byte(a[7:0]);
    end
    ack_chk(req);
  endtask

  task automatic tx_write(input int m, input int a, input int n, input string req);
    mode = 2'(m);
    bus_start();
    send_addr(m, a, req);
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k]); ack_chk("R12");
      ref_mem[page_idx(m, a, k)] = wbuf[k];
    end
    bus_stop();
  endtask

  task automatic tx_read(input int m, input int a, input int n, input string req);
    logic [7:0] b;
    mode = 2'(m);
    bus_start();
    if (m == 0) begin
      send_byte({a[6:0], 1'b1}); ack_chk(req);
    end else begin
      send_addr(m, a, req);
      bus_start();  // repeated start keeps the address (R2)
      send_byte({4'hA, 3'b0, 1'b1}); ack_chk("R2");
    end
    for (int k = 0; k < n; k++) begin
      recv_byte(b);
      chk(b, ref_mem[read_idx(m, a, k)], req);
      if (k == n - 1) send_bit(1'b1);
      else begin
        sda = 1; wt(PH); scl = 1; wt(PH);
        chk({7'b0, sda_out}, 8'h00, "R12");
        scl = 0; wt(PH);
      end
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 8'h00;
    wt(4); rst_n = 1; wt(2);
    // R1: reset state and idle echo
    chk({7'b0, sda_out}, 8'h01, "R1");
    scl = 0; wt(2); sda = 0; wt(2);
    chk({7'b0, sda_out}, 8'h00, "R1");
    sda = 1; wt(2); scl = 1; wt(2);
    tx_read(0, 5, 2, "R1");

    // R5/R6: compact write wraps inside a 4-byte page
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    tx_write(0, 62, 3, "R6");
    tx_read(0, 60, 4, "R6");
    // R7: compact read runs across pages and wraps at 127
    wbuf[0] = 8'h5A; tx_write(0, 127, 1, "R5");
    wbuf[0] = 8'hA5; tx_write(0, 0, 1, "R5");
    tx_read(0, 126, 3, "R7");

    // R8/R10: 8-bit scheme, device bits feed the upper address
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    tx_write(1, 11'h34E, 4, "R10");
    tx_read(1, 11'h34E, 4, "R11");
    wbuf[0] = 8'h77; tx_write(1, 11'h510, 1, "R8");
    tx_read(1, 11'h010, 1, "R8");
    tx_read(1, 11'h510, 1, "R8");

    // R9: 16-bit scheme with page wrap
    wbuf[0] = 8'h9C; wbuf[1] = 8'hD1; wbuf[2] = 8'hE2;
    tx_write(2, 11'h3FE, 3, "R9");
    tx_read(2, 11'h3FE, 3, "R9");
    tx_read(2, 11'h3F0, 1, "R10");

    // R4: mode 3 acts as 16-bit; mode change inside a transaction ignored
    wbuf[0] = 8'h3C; tx_write(3, 11'h123, 1, "R4");
    tx_read(2, 11'h123, 1, "R4");
    mode = 2;
    bus_start();
    mode = 0;
    send_addr(2, 11'h200, "R4");
    send_byte(8'hE7); ack_chk("R4");
    ref_mem[11'h200] = 8'hE7;
    bus_stop();
    tx_read(2, 11'h200, 1, "R4");

    // R13: clock pulses with no open transaction write nothing
    scl = 0; wt(PH);
    for (int i = 0; i < 20; i++) begin
      sda = 1'(i); wt(PH); scl = 1; wt(PH); scl = 0; wt(PH);
    end
    sda = 1; wt(PH); scl = 1; wt(PH);
    tx_read(0, 62, 2, "R13");

    // R3: stop closes the transaction; output follows sda again
    mode = 0;
    bus_start(); send_byte({7'd40, 1'b0}); ack_chk("R12");
    bus_stop();
    scl = 0; wt(PH); sda = 0; wt(PH);
    chk({7'b0, sda_out}, 8'h00, "R3");
    sda = 1; wt(PH); scl = 1; wt(PH);

    // random traffic
    void'($urandom(32'd1234));
    for (int it = 0; it < 24; it++) begin
      int m, a, n;
      m = int'($urandom % 4);
      a = (m == 0) ? int'($urandom % 128) : int'($urandom % DEPTH);
      n = 1 + int'($urandom % 5);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      tx_write(m, a, n, (m == 0) ? "R6" : "R10");
      tx_read(m, a, n, "R11");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule